// File: doc/BRIEF.md
# Accumulator and Link Next-State Unit

This unit is the arithmetic heart of a small accumulator machine. Each cycle the surrounding datapath presents the current 16-bit accumulator, the 1-bit link flag, the 16-bit memory data word, the 8-bit input character and a 12-bit register-operation field. A one-hot operation select says which class of operation is being executed. The unit returns the next accumulator and link values. For conditional-skip operations it raises a skip request, and for the stop operation it raises a halt request.

The unit is purely combinational. The caller owns the accumulator and link registers, the program counter and the instruction decoder. It writes the returned values back and acts on the skip and halt requests. Within the register-operation field each bit names one action. Rotations pass through the link bit, so the accumulator and the link together behave as a 17-bit ring. The skip tests look at the sign of the accumulator, whether it is zero, and the link.

Top module: `acc_link_unit`

## Requirements
- R1: `op_sel` bit 0 selects AND, bit 1 selects ADD, bit 2 selects LOAD, bit 3 selects the register-field operation and bit 4 selects INPUT. When several bits are set, the lowest-numbered one wins. With `op_sel` all zero, `acc_out`/`link_out` equal `acc_in`/`link_in` and neither request is raised.
- R2: AND gives `acc_out = acc_in & data_in`, and the link is unchanged.
- R3: ADD gives `{link_out, acc_out} = acc_in + data_in`, with the carry-out going to the link.
- R4: LOAD gives `acc_out = data_in`, and the link is unchanged.
- R5: INPUT replaces `acc_out[7:0]` with `char_in`. `acc_out[15:8]` and the link are unchanged.
- R6: In the register field, bit 11 clears the accumulator, bit 10 clears the link, bit 9 inverts the accumulator and bit 8 inverts the link. In each case the other register is unchanged.
- R7: Field bit 7 rotates right through the link: the accumulator shifts right by one, the old link enters bit 15, and the old bit 0 goes to the link.
- R8: Field bit 6 rotates left through the link: the accumulator shifts left by one, the old link enters bit 0, and the old bit 15 goes to the link.
- R9: Field bit 5 increments the accumulator, modulo 2^16. The link is unchanged.
- R10: When several of field bits 11..5 are set, only the lowest-numbered of them takes effect. Field bits 4..0 never alter the accumulator or the link.
- R11: `skip_req` is the OR of the enabled tests: bit 4 when `acc_in[15]` is 0, bit 3 when `acc_in[15]` is 1, bit 2 when `acc_in` is zero, and bit 1 when `link_in` is 0. All tests use the input values. The request is raised only while the register-field operation is the selected one.
- R12: `halt_req` equals field bit 0 while the register-field operation is selected, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation class request, one hot; the lowest set bit wins |
| acc_in | input | 16 | Current accumulator |
| link_in | input | 1 | Current link flag |
| data_in | input | 16 | Memory data operand |
| char_in | input | 8 | Input character |
| reg_field | input | 12 | Register-operation field |
| acc_out | output | 16 | Next accumulator |
| link_out | output | 1 | Next link flag |
| skip_req | output | 1 | Request to skip the next instruction |
| halt_req | output | 1 | Request to stop the machine |

## Verification
Several properties are checked on every input change:
- The idle hold.
- The ADD sum with its carry.
- The AND result never holding a bit that is clear in the data word.
- The untouched high byte on INPUT.
- The rotations preserving the population count of the 17-bit accumulator-plus-link ring.
- Skip and halt requests appearing only under the register-field operation.

The exact rotate values, the priority between conflicting field bits and between select bits, and the increment wrap need concrete scenarios from the bench. So does the full-circle property: seventeen rotations in either direction return the starting state.

// File: rtl/acc_link_pkg.sv
// Package: shared bit positions for the accumulator and link unit.
// Assumes a 12-bit register-operation field and a 5-bit operation select.
package acc_link_pkg;

    // Operation select bit positions (lowest set bit wins)
    localparam int OPI_AND   = 0;
    localparam int OPI_ADD   = 1;
    localparam int OPI_LOAD  = 2;
    localparam int OPI_REG   = 3;
    localparam int OPI_INPUT = 4;
    localparam int OP_COUNT  = 5;

    // Register field layout
    localparam int FIELD_W    = 12;
    localparam int FB_CLR_ACC = 11;
    localparam int FB_CLR_LNK = 10;
    localparam int FB_INV_ACC = 9;
    localparam int FB_INV_LNK = 8;
    localparam int FB_ROT_R   = 7;
    localparam int FB_ROT_L   = 6;
    localparam int FB_INC     = 5;
    localparam int FB_SKP_POS = 4;
    localparam int FB_SKP_NEG = 3;
    localparam int FB_SKP_ZRO = 2;
    localparam int FB_SKP_LNK = 1;
    localparam int FB_HALT    = 0;

    // Widths of the two field groups
    localparam int FN_W   = FB_CLR_ACC - FB_INC + 1;     // AC/link actions
    localparam int TEST_W = FB_SKP_POS - FB_HALT + 1;    // skip tests and halt

endpackage

// File: rtl/acc_link_opsel.sv
// Module: acc_link_opsel
// Turns a multi-hot request vector into a one-hot grant.
// The lowest-numbered set bit wins. An all-zero request gives an all-zero grant.
module acc_link_opsel #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Scan from the top down so that the lowest set bit overwrites the others
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_link_memops.sv
// Module: acc_link_memops
// Results of the data-operand and input operations: AND, ADD, LOAD, INPUT.
// Assumes CHAR_W < DATA_W. All results are offered in parallel, and the top module chooses one.
module acc_link_memops #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHAR_W-1:0] char_in,
    output logic [DATA_W-1:0] and_acc,
    output logic [DATA_W-1:0] add_acc,
    output logic              add_carry,
    output logic [DATA_W-1:0] load_acc,
    output logic [DATA_W-1:0] input_acc
);

    localparam int HI_W = DATA_W - CHAR_W;

    // Bitwise AND and straight load
    always_comb begin
        and_acc  = acc_in & data_in;
        load_acc = data_in;
    end

    // Full-width add, with the carry-out kept for the link
    always_comb begin
        {add_carry, add_acc} = {1'b0, acc_in} + {1'b0, data_in};
    end

    // Input character replaces the low bits and the upper bits are kept
    always_comb begin
        input_acc = {acc_in[DATA_W-1 -: HI_W], char_in};
    end

endmodule

// File: rtl/acc_link_regops.sv
// Module: acc_link_regops
// Accumulator and link actions selected by the upper bits of the register field.
// When several action bits are set, only the lowest-numbered one is applied.
// The input slice holds field bits FB_CLR_ACC down to FB_INC.
module acc_link_regops
    import acc_link_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [FN_W-1:0]   fn_bits,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              link_out
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [FN_W-1:0] pick;

    // Keep only the lowest-numbered action bit
    acc_link_opsel #(.N(FN_W)) i_pick (
        .req (fn_bits),
        .gnt (pick)
    );

    // Apply the single chosen action, or pass the inputs through when none is set
    always_comb begin
        acc_out  = acc_in;
        link_out = link_in;
        if (pick[FB_CLR_ACC - FB_INC]) begin
            acc_out = '0;
        end else if (pick[FB_CLR_LNK - FB_INC]) begin
            link_out = 1'b0;
        end else if (pick[FB_INV_ACC - FB_INC]) begin
            acc_out = ~acc_in;
        end else if (pick[FB_INV_LNK - FB_INC]) begin
            link_out = ~link_in;
        end else if (pick[FB_ROT_R - FB_INC]) begin
            acc_out  = {link_in, acc_in[DATA_W-1:1]};
            link_out = acc_in[0];
        end else if (pick[FB_ROT_L - FB_INC]) begin
            acc_out  = {acc_in[DATA_W-2:0], link_in};
            link_out = acc_in[DATA_W-1];
        end else if (pick[FB_INC - FB_INC]) begin
            acc_out = acc_in + ONE;
        end
    end

endmodule

// File: rtl/acc_link_tests.sv
// Module: acc_link_tests
// Skip and halt requests taken from the low bits of the register field.
// Every test looks at the incoming accumulator and link. The enabled tests are ORed.
module acc_link_tests
    import acc_link_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              enable,
    input  logic [TEST_W-1:0] test_bits,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    output logic              skip_req,
    output logic              halt_req
);

    logic [TEST_W-1:0] hit;

    // One condition per skip bit, ANDed with its enable
    always_comb begin
        hit                          = '0;
        hit[FB_SKP_POS - FB_HALT]    = test_bits[FB_SKP_POS - FB_HALT] & ~acc_in[DATA_W-1];
        hit[FB_SKP_NEG - FB_HALT]    = test_bits[FB_SKP_NEG - FB_HALT] &  acc_in[DATA_W-1];
        hit[FB_SKP_ZRO - FB_HALT]    = test_bits[FB_SKP_ZRO - FB_HALT] & (acc_in == '0);
        hit[FB_SKP_LNK - FB_HALT]    = test_bits[FB_SKP_LNK - FB_HALT] & ~link_in;
    end

    // Requests exist only while the register-field operation is the chosen one
    always_comb begin
        skip_req = enable & (|hit);
        halt_req = enable & test_bits[FB_HALT - FB_HALT];
    end

endmodule

// File: rtl/acc_link_unit.sv
// Module: acc_link_unit (top)
// Next-state logic for an accumulator and its link flag.
// Purely combinational. The caller holds the registers and acts on skip and halt.
// Assumes the select is meant to be one-hot. If it is not, the lowest set bit wins.
module acc_link_unit
    import acc_link_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic [OP_COUNT-1:0] op_sel,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic                link_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [CHAR_W-1:0]   char_in,
    input  logic [FIELD_W-1:0]  reg_field,
    output logic [DATA_W-1:0]   acc_out,
    output logic                link_out,
    output logic                skip_req,
    output logic                halt_req
);

    logic [OP_COUNT-1:0] op_gnt;
    logic [DATA_W-1:0]   and_acc, add_acc, load_acc, input_acc, reg_acc;
    logic                add_carry, reg_link;

    acc_link_opsel #(.N(OP_COUNT)) i_opsel (
        .req (op_sel),
        .gnt (op_gnt)
    );

    acc_link_memops #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_memops (
        .acc_in    (acc_in),
        .data_in   (data_in),
        .char_in   (char_in),
        .and_acc   (and_acc),
        .add_acc   (add_acc),
        .add_carry (add_carry),
        .load_acc  (load_acc),
        .input_acc (input_acc)
    );

    acc_link_regops #(.DATA_W(DATA_W)) i_regops (
        .fn_bits  (reg_field[FB_CLR_ACC:FB_INC]),
        .acc_in   (acc_in),
        .link_in  (link_in),
        .acc_out  (reg_acc),
        .link_out (reg_link)
    );

    acc_link_tests #(.DATA_W(DATA_W)) i_tests (
        .enable    (op_gnt[OPI_REG]),
        .test_bits (reg_field[FB_SKP_POS:FB_HALT]),
        .acc_in    (acc_in),
        .link_in   (link_in),
        .skip_req  (skip_req),
        .halt_req  (halt_req)
    );

    // Choose the result of the granted operation class, or hold when none is granted
    always_comb begin
        acc_out  = acc_in;
        link_out = link_in;
        if (op_gnt[OPI_AND]) begin
            acc_out = and_acc;
        end else if (op_gnt[OPI_ADD]) begin
            acc_out  = add_acc;
            link_out = add_carry;
        end else if (op_gnt[OPI_LOAD]) begin
            acc_out = load_acc;
        end else if (op_gnt[OPI_REG]) begin
            acc_out  = reg_acc;
            link_out = reg_link;
        end else if (op_gnt[OPI_INPUT]) begin
            acc_out = input_acc;
        end
    end

endmodule

// File: rtl/acc_link_unit_chk.sv
// Module: acc_link_unit_chk
// Property checker for acc_link_unit, attached by bind.
// The block has no clock, so the checks are immediate assertions evaluated whenever the ports change.
// Nothing is checked while any input is unknown.
module acc_link_unit_chk
    import acc_link_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input logic [OP_COUNT-1:0] op_sel,
    input logic [DATA_W-1:0]   acc_in,
    input logic                link_in,
    input logic [DATA_W-1:0]   data_in,
    input logic [CHAR_W-1:0]   char_in,
    input logic [FIELD_W-1:0]  reg_field,
    input logic [DATA_W-1:0]   acc_out,
    input logic                link_out,
    input logic                skip_req,
    input logic                halt_req
);

    logic inputs_known;
    logic only_and, only_add, only_input, reg_won, rotate_won;

    // Work out, independently of the design, which class and which field action won
    always_comb begin
        inputs_known = !$isunknown({op_sel, acc_in, link_in, data_in, char_in, reg_field});
        only_and     = op_sel[OPI_AND];
        only_add     = op_sel[OPI_ADD] && !op_sel[OPI_AND];
        reg_won      = op_sel[OPI_REG] && (op_sel[OPI_LOAD:OPI_AND] == '0);
        only_input   = op_sel == (OP_COUNT'(1) << OPI_INPUT);
        rotate_won   = reg_won && (reg_field[FB_INC] == 1'b0)
                       && (reg_field[FB_ROT_L] || reg_field[FB_ROT_R]);
    end

    // Port relations that must hold after every input change
    always_comb begin
        if (inputs_known) begin
            // R1: idle select holds the state and raises nothing
            assert_idle_hold_R1: assert (op_sel != '0 ||
                (acc_out == acc_in && link_out == link_in && !skip_req && !halt_req))
                else $error("idle select changed state");
            // R2: AND result has no bit that is clear in the data word
            assert_and_subset_R2: assert (!only_and ||
                ((acc_out & ~data_in) == '0 && link_out == link_in))
                else $error("AND result outside data word");
            // R3: ADD result and carry form the full sum
            assert_add_sum_R3: assert (!only_add ||
                {link_out, acc_out} == ({1'b0, acc_in} + {1'b0, data_in}))
                else $error("ADD sum mismatch");
            // R5: INPUT keeps the upper byte and the link
            assert_input_high_R5: assert (!only_input ||
                (acc_out[DATA_W-1:CHAR_W] == acc_in[DATA_W-1:CHAR_W] && link_out == link_in))
                else $error("INPUT disturbed upper bits");
            // R7 and R8: a rotation keeps the number of ones in the 17-bit ring
            assert_rotate_ring_R7: assert (!rotate_won ||
                $countones({link_out, acc_out}) == $countones({link_in, acc_in}))
                else $error("rotate lost or gained a bit");
            // R11: skip only under the register-field operation
            assert_skip_gated_R11: assert (reg_won || !skip_req)
                else $error("skip outside register operation");
            // R12: halt follows field bit 0 under the register-field operation only
            assert_halt_gated_R12: assert (halt_req == (reg_won && reg_field[FB_HALT]))
                else $error("halt request mismatch");
        end
    end

endmodule

bind acc_link_unit acc_link_unit_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_acc_link_unit_chk (
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .link_in   (link_in),
    .data_in   (data_in),
    .char_in   (char_in),
    .reg_field (reg_field),
    .acc_out   (acc_out),
    .link_out  (link_out),
    .skip_req  (skip_req),
    .halt_req  (halt_req)
);

// File: tb/test_acc_link_unit.sv
// Bench for acc_link_unit.
// Walks a vector table, then runs directed full-circle rotation and increment-wrap tests.
// Inputs are driven on the falling edge and outputs sampled 2 ns later.
module test_acc_link_unit;

    localparam int VW = 81;
    localparam int NV = 32;

    logic       clk = 1'b0;
    logic [4:0] op_sel;
    logic [15:0] acc_in, data_in, acc_out;
    logic        link_in, link_out, skip_req, halt_req;
    logic [7:0]  char_in;
    logic [11:0] reg_field;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    acc_link_unit i_acc_link_unit (
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .link_in   (link_in),
        .data_in   (data_in),
        .char_in   (char_in),
        .reg_field (reg_field),
        .acc_out   (acc_out),
        .link_out  (link_out),
        .skip_req  (skip_req),
        .halt_req  (halt_req)
    );

    // Row fields: req, op, acc, link, data, char, field, exp acc, exp link, exp skip, exp halt
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2,  5'b00001, 16'hF0F0, 1'b1, 16'h3C3C, 8'h00, 12'h000, 16'h3030, 1'b1, 1'b0, 1'b0}, // R2
        {4'd3,  5'b00010, 16'h1234, 1'b1, 16'h1111, 8'h00, 12'h000, 16'h2345, 1'b0, 1'b0, 1'b0}, // R3
        {4'd3,  5'b00010, 16'hFFFF, 1'b0, 16'h0002, 8'h00, 12'h000, 16'h0001, 1'b1, 1'b0, 1'b0}, // R3 carry
        {4'd4,  5'b00100, 16'hAAAA, 1'b1, 16'h5A5A, 8'h00, 12'h000, 16'h5A5A, 1'b1, 1'b0, 1'b0}, // R4
        {4'd5,  5'b10000, 16'hABCD, 1'b0, 16'h0000, 8'h7E, 12'h000, 16'hAB7E, 1'b0, 1'b0, 1'b0}, // R5
        {4'd6,  5'b01000, 16'h1234, 1'b1, 16'h0000, 8'h00, 12'h800, 16'h0000, 1'b1, 1'b0, 1'b0}, // R6
        {4'd6,  5'b01000, 16'h1234, 1'b1, 16'h0000, 8'h00, 12'h400, 16'h1234, 1'b0, 1'b0, 1'b0}, // R6
        {4'd6,  5'b01000, 16'h00FF, 1'b0, 16'h0000, 8'h00, 12'h200, 16'hFF00, 1'b0, 1'b0, 1'b0}, // R6
        {4'd6,  5'b01000, 16'h00FF, 1'b0, 16'h0000, 8'h00, 12'h100, 16'h00FF, 1'b1, 1'b0, 1'b0}, // R6
        {4'd7,  5'b01000, 16'h8001, 1'b0, 16'h0000, 8'h00, 12'h080, 16'h4000, 1'b1, 1'b0, 1'b0}, // R7
        {4'd7,  5'b01000, 16'h0002, 1'b1, 16'h0000, 8'h00, 12'h080, 16'h8001, 1'b0, 1'b0, 1'b0}, // R7
        {4'd8,  5'b01000, 16'h8001, 1'b0, 16'h0000, 8'h00, 12'h040, 16'h0002, 1'b1, 1'b0, 1'b0}, // R8
        {4'd8,  5'b01000, 16'h4000, 1'b1, 16'h0000, 8'h00, 12'h040, 16'h8001, 1'b0, 1'b0, 1'b0}, // R8
        {4'd9,  5'b01000, 16'hFFFF, 1'b0, 16'h0000, 8'h00, 12'h020, 16'h0000, 1'b0, 1'b0, 1'b0}, // R9 wrap
        {4'd9,  5'b01000, 16'h0041, 1'b1, 16'h0000, 8'h00, 12'h020, 16'h0042, 1'b1, 1'b0, 1'b0}, // R9
        {4'd10, 5'b01000, 16'h0005, 1'b0, 16'h0000, 8'h00, 12'h820, 16'h0006, 1'b0, 1'b0, 1'b0}, // R10
        {4'd10, 5'b01000, 16'h0000, 1'b0, 16'h0000, 8'h00, 12'h300, 16'h0000, 1'b1, 1'b0, 1'b0}, // R10
        {4'd10, 5'b01000, 16'h8000, 1'b0, 16'h0000, 8'h00, 12'h0C0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R10
        {4'd10, 5'b01000, 16'h0001, 1'b0, 16'h0000, 8'h00, 12'h030, 16'h0002, 1'b0, 1'b1, 1'b0}, // R10 with R11
        {4'd11, 5'b01000, 16'h7FFF, 1'b0, 16'h0000, 8'h00, 12'h010, 16'h7FFF, 1'b0, 1'b1, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h8000, 1'b0, 16'h0000, 8'h00, 12'h010, 16'h8000, 1'b0, 1'b0, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h8000, 1'b1, 16'h0000, 8'h00, 12'h008, 16'h8000, 1'b1, 1'b1, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h0000, 1'b1, 16'h0000, 8'h00, 12'h004, 16'h0000, 1'b1, 1'b1, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h0001, 1'b1, 16'h0000, 8'h00, 12'h004, 16'h0001, 1'b1, 1'b0, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h0123, 1'b0, 16'h0000, 8'h00, 12'h002, 16'h0123, 1'b0, 1'b1, 1'b0}, // R11
        {4'd11, 5'b01000, 16'h0123, 1'b1, 16'h0000, 8'h00, 12'h002, 16'h0123, 1'b1, 1'b0, 1'b0}, // R11
        {4'd11, 5'b00001, 16'h0000, 1'b0, 16'hFFFF, 8'h00, 12'h016, 16'h0000, 1'b0, 1'b0, 1'b0}, // R11 gated
        {4'd12, 5'b01000, 16'h1234, 1'b1, 16'h0000, 8'h00, 12'h001, 16'h1234, 1'b1, 1'b0, 1'b1}, // R12
        {4'd12, 5'b00100, 16'h1234, 1'b1, 16'h4321, 8'h00, 12'h001, 16'h4321, 1'b1, 1'b0, 1'b0}, // R12 gated
        {4'd1,  5'b00000, 16'h1357, 1'b1, 16'hFFFF, 8'hAA, 12'h801, 16'h1357, 1'b1, 1'b0, 1'b0}, // R1 idle
        {4'd1,  5'b00011, 16'hFFFF, 1'b0, 16'h0F0F, 8'h00, 12'h000, 16'h0F0F, 1'b0, 1'b0, 1'b0}, // R1 priority
        {4'd1,  5'b11000, 16'h1234, 1'b1, 16'h0000, 8'h55, 12'h800, 16'h0000, 1'b1, 1'b0, 1'b0}  // R1 priority
    };

    // Drive one set of inputs on the falling edge and let them settle
    task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic l,
                         input logic [15:0] d, input logic [7:0] c, input logic [11:0] f);
        @(negedge clk);
        op_sel = op; acc_in = a; link_in = l; data_in = d; char_in = c; reg_field = f;
        #2;
    endtask

    // Compare all four outputs against expectations and count the result
    task automatic expect_out(input string tag, input logic [15:0] xa, input logic xl,
                              input logic xs, input logic xh);
        checks++;
        if (acc_out !== xa || link_out !== xl || skip_req !== xs || halt_req !== xh) begin
            failures++;
            $display("FAIL %s: acc=%h link=%b skip=%b halt=%b expected acc=%h link=%b skip=%b halt=%b",
                     tag, acc_out, link_out, skip_req, halt_req, xa, xl, xs, xh);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic        l;
        op_sel = '0; acc_in = '0; link_in = 1'b0; data_in = '0; char_in = '0; reg_field = '0;

        // Idle state after start-up (R1)
        apply(5'b0, 16'h0000, 1'b0, 16'h0000, 8'h00, 12'h000);
        expect_out("R1 start-up idle", 16'h0000, 1'b0, 1'b0, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] row;
            row = VEC[v];
            apply(row[76:72], row[71:56], row[55], row[54:39], row[38:31], row[30:19]);
            expect_out($sformatf("R%0d vector %0d", row[80:77], v),
                       row[18:3], row[2], row[1], row[0]);
        end

        // R7: seventeen right rotations return the 17-bit ring to its start
        a = 16'h8421; l = 1'b1;
        for (int k = 0; k < 17; k++) begin
            apply(5'b01000, a, l, 16'h0000, 8'h00, 12'h080);
            a = acc_out; l = link_out;
        end
        expect_out("R7 full circle", a, l, 1'b0, 1'b0);
        checks++;
        if (a !== 16'h8421 || l !== 1'b1) begin
            failures++;
            $display("FAIL R7 full circle: acc=%h link=%b expected acc=8421 link=1", a, l);
        end

        // R8: seventeen left rotations return the 17-bit ring to its start
        a = 16'h0C35; l = 1'b0;
        for (int k = 0; k < 17; k++) begin
            apply(5'b01000, a, l, 16'h0000, 8'h00, 12'h040);
            a = acc_out; l = link_out;
        end
        checks++;
        if (a !== 16'h0C35 || l !== 1'b0) begin
            failures++;
            $display("FAIL R8 full circle: acc=%h link=%b expected acc=0c35 link=0", a, l);
        end

        // R9: increment near the wrap point, link held at 1
        for (int k = 0; k < 4; k++) begin
            logic [15:0] start;
            start = 16'hFFFE + 16'(k);
            apply(5'b01000, start, 1'b1, 16'h0000, 8'h00, 12'h020);
            expect_out("R9 wrap sweep", start + 16'h0001, 1'b1, 1'b0, 1'b0);
        end

        // R3: maximum operands give a full carry
        apply(5'b00010, 16'hFFFF, 1'b0, 16'hFFFF, 8'h00, 12'h000);
        expect_out("R3 max add", 16'hFFFE, 1'b1, 1'b0, 1'b0);

        // R5: input with all-ones character keeps the high byte zero
        apply(5'b10000, 16'h0000, 1'b1, 16'hFFFF, 8'hFF, 12'hFFF);
        expect_out("R5 input ignores field", 16'h00FF, 1'b1, 1'b0, 1'b0);

        // R10 and R11: all field bits set gives an increment, with the zero, link and sign tests active
        apply(5'b01000, 16'h0000, 1'b0, 16'h0000, 8'h00, 12'hFFF);
        expect_out("R10 all bits", 16'h0001, 1'b0, 1'b1, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule